// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt events from a parameterized set of peripheral sources and decides which one, if any, the CPU should service. Each source owns a pending flag, set by a one-cycle event pulse, and a 3-bit priority level. A source with level 0 is switched off, and 7 is the most urgent level. A source competes for service only when three conditions hold: the global enable input is high, its pending flag is set, and its level is strictly above the processor's current level.

Among the competing sources, the block picks the one with the highest level. On a tie, the lowest source index wins. The interrupt request and the index of the winner are presented combinationally. When the CPU returns a one-cycle accept pulse, only the winner's pending flag is cleared.

Software reaches each source through a small register port addressed by source index. A level write and a pending write have separate strobes, so neither field disturbs the other. A pending write of 0 clears the flag. A pending write of 1 does nothing.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `glb_en` is 0, `irq_req` is 0, whatever the pending flags and levels are.
- R2: A 1 on `src_evt[i]` at a clock edge sets pending flag i at that edge.
- R3: When `irq_ack` is 1 while `irq_req` is 1, the edge clears the pending flag of the source named by `irq_vec`, and only that flag.
- R4: When `bus_we_req` is 1, bit 3 of `bus_wdata` gives the value for the pending flag of source `bus_addr`. A 0 clears the flag. A 1 leaves the flag unchanged.
- R5: A source is eligible only if its level is greater than `cpu_lvl`. Level 0 is never eligible, and a `cpu_lvl` of 7 blocks every source.
- R6: Among eligible sources, `irq_vec` names the one with the highest level, taking the lowest index on a tie. `irq_req` is 1 whenever any source is eligible.
- R7: When `bus_we_lvl` is 1, bits 2:0 of `bus_wdata` become the level of source `bus_addr`. A level write never changes a pending flag, and a pending write never changes a level.
- R8: If an event and an accept hit the same source in the same cycle, its pending flag stays 1.
- R9: After reset, all pending flags, levels and `bus_rdata` are 0, and `irq_req` is 0.
- R10: `bus_rdata` is registered. One cycle after `bus_addr` is presented, bit 3 holds that source's pending flag and bits 2:0 hold its level.

Every field position the bench relies on is stated above: bit 3 is the pending flag, bits 2:0 are the level, and the address is the source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | N_SRC | One-cycle event pulse per source |
| bus_addr | input | SEL_W | Source index for register access |
| bus_we_lvl | input | 1 | Write strobe for the level field |
| bus_we_req | input | 1 | Write strobe for the pending flag (only 0 takes effect) |
| bus_wdata | input | LVL_W+1 | Write data: bit 3 pending, bits 2:0 level |
| bus_rdata | output | LVL_W+1 | Registered read data for `bus_addr` |
| glb_en | input | 1 | Global maskable-interrupt enable |
| cpu_lvl | input | LVL_W | Current processor priority level |
| irq_ack | input | 1 | One-cycle accept pulse from the CPU |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | SEL_W | Index of the winning source |

## Verification
Two functions can land on the same source in one cycle: a fresh event, which sets the flag, and the accept pulse, which clears it. The bench provokes this collision by raising that source's event pulse during the same low clock phase in which it drives the accept pulse for the source currently named by `irq_vec`. After the edge it requires the request to stay asserted for that same index, and a register read must show the flag still set. A second directed case accepts one of two pending sources and checks that the other source's flag survives and becomes the new winner.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_slot.sv
module irq_slot
  import irq_prio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic ack_hit,
  input  logic wr_req,
  input  logic wr_req_val,
  input  logic wr_lvl,
  input  lvl_t wr_lvl_val,
  output logic pend,
  output lvl_t lvl
);
  // event beats every clear source
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (evt) begin
      pend <= 1'b1;
    end else if (ack_hit || (wr_req && !wr_req_val)) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= '0;
    end else if (wr_lvl) begin
      lvl <= wr_lvl_val;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   en,
  input  lvl_t                   cpu_lvl,
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output logic                   any,
  output logic [SEL_W-1:0]       idx
);
  lvl_t best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    // ascending scan with strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (en && pend[i] && (lvl_flat[i*LVL_W +: LVL_W] > cpu_lvl)) begin
        if (!any || (lvl_flat[i*LVL_W +: LVL_W] > best)) begin
          any  = 1'b1;
          idx  = SEL_W'(i);
          best = lvl_flat[i*LVL_W +: LVL_W];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SRC-1:0]   src_evt,
  input  logic [SEL_W-1:0]   bus_addr,
  input  logic               bus_we_lvl,
  input  logic               bus_we_req,
  input  logic [LVL_W:0]     bus_wdata,
  output logic [LVL_W:0]     bus_rdata,
  input  logic               glb_en,
  input  logic [LVL_W-1:0]   cpu_lvl,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [SEL_W-1:0]   irq_vec
);
  localparam int DW = LVL_W + 1;

  logic [N_SRC-1:0]       pend;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic [DW-1:0]          rd_mux;

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    logic sel;
    lvl_t lv;
    assign sel = (32'(bus_addr) == g);
    irq_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .evt        (src_evt[g]),
      .ack_hit    (irq_ack && irq_req && (32'(irq_vec) == g)),
      .wr_req     (bus_we_req && sel),
      .wr_req_val (bus_wdata[LVL_W]),
      .wr_lvl     (bus_we_lvl && sel),
      .wr_lvl_val (bus_wdata[LVL_W-1:0]),
      .pend       (pend[g]),
      .lvl        (lv)
    );
    assign lvl_flat[g*LVL_W +: LVL_W] = lv;
  end

  irq_pick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_pick (
    .en       (glb_en),
    .cpu_lvl  (cpu_lvl),
    .pend     (pend),
    .lvl_flat (lvl_flat),
    .any      (irq_req),
    .idx      (irq_vec)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (32'(bus_addr) == i) rd_mux = {pend[i], lvl_flat[i*LVL_W +: LVL_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int SEL_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_SRC-1:0]       src_evt,
  input logic [SEL_W-1:0]       bus_addr,
  input logic                   bus_we_req,
  input logic [LVL_W:0]         bus_wdata,
  input logic                   glb_en,
  input logic [LVL_W-1:0]       cpu_lvl,
  input logic                   irq_ack,
  input logic                   irq_req,
  input logic [SEL_W-1:0]       irq_vec,
  input logic [N_SRC-1:0]       pend,
  input logic [N_SRC*LVL_W-1:0] lvl_flat
);
  // R1
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en |-> !irq_req);

  // R5
  top_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_lvl == LVL_W'(LVL_MAX)) |-> !irq_req);

  // R5
  win_above_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (lvl_flat[irq_vec*LVL_W +: LVL_W] > cpu_lvl) && pend[irq_vec]);

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && !src_evt[irq_vec]) |=> !pend[$past(irq_vec)]);

  // R8
  ack_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && src_evt[irq_vec]) |=> pend[$past(irq_vec)]);

  // R4
  sw_noset_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we_req && bus_wdata[LVL_W] && !pend[bus_addr] && !src_evt[bus_addr])
      |=> !pend[$past(bus_addr)]);

  for (genvar g = 0; g < N_SRC; g++) begin : g_evt
    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      src_evt[g] |=> pend[g]);
  end
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_evt    (src_evt),
  .bus_addr   (bus_addr),
  .bus_we_req (bus_we_req),
  .bus_wdata  (bus_wdata),
  .glb_en     (glb_en),
  .cpu_lvl    (cpu_lvl),
  .irq_ack    (irq_ack),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .pend       (pend),
  .lvl_flat   (lvl_flat)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int N  = 8;
  localparam int SW = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_evt = '0;
  logic [SW-1:0] bus_addr = '0;
  logic         bus_we_lvl = 1'b0;
  logic         bus_we_req = 1'b0;
  logic [3:0]   bus_wdata = '0;
  logic [3:0]   bus_rdata;
  logic         glb_en = 1'b0;
  logic [2:0]   cpu_lvl = '0;
  logic         irq_ack = 1'b0;
  logic         irq_req;
  logic [SW-1:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N)) dut_i (.*);

  // {event mask, levels L7..L0, enable, cpu level, expected irq, expected vec}
  localparam logic [39:0] TBL [10] = '{
    {8'h01, 24'h000003, 1'b1, 3'd2, 1'b1, 3'd0},
    {8'h01, 24'h000003, 1'b1, 3'd3, 1'b0, 3'd0},
    {8'h01, 24'h000003, 1'b0, 3'd0, 1'b0, 3'd0},
    {8'h06, 24'h000120, 1'b1, 3'd0, 1'b1, 3'd1},
    {8'h86, 24'hC00150, 1'b1, 3'd4, 1'b1, 3'd7},
    {8'h80, 24'h000000, 1'b1, 3'd0, 1'b0, 3'd0},
    {8'hFF, 24'hFFFFFF, 1'b1, 3'd6, 1'b1, 3'd0},
    {8'hFF, 24'hFFFFFF, 1'b1, 3'd7, 1'b0, 3'd0},
    {8'h30, 24'h011000, 1'b1, 3'd0, 1'b1, 3'd5},
    {8'h08, 24'h000200, 1'b1, 3'd0, 1'b1, 3'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_lvl(input int idx, input int v);
    @(negedge clk);
    bus_addr = SW'(idx); bus_wdata = 4'(v & 7); bus_we_lvl = 1'b1;
    @(negedge clk);
    bus_we_lvl = 1'b0;
  endtask

  task automatic wr_req(input int idx, input bit v);
    @(negedge clk);
    bus_addr = SW'(idx); bus_wdata = {v, 3'b000}; bus_we_req = 1'b1;
    @(negedge clk);
    bus_we_req = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic rd(input int idx, output logic [3:0] d);
    @(negedge clk);
    bus_addr = SW'(idx);
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(irq_req == 1'b0, "R9 irq after reset", int'(irq_req), 0);
    chk(bus_rdata == 4'd0, "R9 rdata after reset", int'(bus_rdata), 0);
    glb_en = 1'b1;
    pulse(8'h01);
    chk(irq_req == 1'b0, "R9 level zero after reset blocks", int'(irq_req), 0);
    rd(0, d);
    chk(d == 4'b1000, "R2 event sets pending, R9 level 0", int'(d), 8);

    // table walk: R1 R5 R6 R2
    for (int k = 0; k < 10; k++) begin
      logic [39:0] e;
      e = TBL[k];
      glb_en = 1'b0;
      for (int i = 0; i < N; i++) wr_req(i, 1'b0);
      for (int i = 0; i < N; i++) wr_lvl(i, int'(e[8 + i*3 +: 3]));
      pulse(e[39:32]);
      @(negedge clk);
      glb_en = e[7]; cpu_lvl = e[6:4];
      #1;
      chk(irq_req == e[3], $sformatf("R1/R5/R6 table %0d irq", k), int'(irq_req), int'(e[3]));
      if (e[3])
        chk(irq_vec == e[2:0], $sformatf("R6 table %0d vec", k), int'(irq_vec), int'(e[2:0]));
    end

    // clean slate
    glb_en = 1'b1; cpu_lvl = 3'd0;
    for (int i = 0; i < N; i++) begin wr_req(i, 1'b0); wr_lvl(i, 0); end

    // R4 write of 1 has no effect
    wr_req(2, 1'b1);
    rd(2, d);
    chk(d[3] == 1'b0, "R4 write 1 does not set", int'(d[3]), 0);
    // R4 write of 0 clears; R7 level survives
    wr_lvl(3, 5);
    pulse(8'h08);
    rd(3, d);
    chk(d == 4'b1101, "R7 level write keeps pending", int'(d), 13);
    wr_req(3, 1'b1);
    rd(3, d);
    chk(d == 4'b1101, "R4 write 1 leaves set flag", int'(d), 13);
    wr_req(3, 1'b0);
    rd(3, d);
    chk(d == 4'b0101, "R4 clear by 0, R7 level kept", int'(d), 5);
    chk(irq_req == 1'b0, "R4 cleared source no irq", int'(irq_req), 0);
    wr_lvl(3, 0);

    // R3 accept clears only the winner
    wr_lvl(1, 3); wr_lvl(2, 5);
    pulse(8'h06);
    chk(irq_req && irq_vec == 3'd2, "R3 winner before accept", int'(irq_vec), 2);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(irq_req && irq_vec == 3'd1, "R3 other source remains", int'(irq_vec), 1);
    rd(2, d);
    chk(d == 4'b0101, "R3 accepted flag cleared", int'(d), 5);

    // R8 accept and new event collide on the same source
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R3 second accept clears", int'(irq_req), 0);
    pulse(8'h04);
    chk(irq_req && irq_vec == 3'd2, "R8 setup winner", int'(irq_vec), 2);
    @(negedge clk); irq_ack = 1'b1; src_evt = 8'h04;
    @(negedge clk); irq_ack = 1'b0; src_evt = '0;
    chk(irq_req && irq_vec == 3'd2, "R8 event wins over accept", int'(irq_req), 1);
    rd(2, d);
    chk(d[3] == 1'b1, "R8 pending still set", int'(d[3]), 1);

    // R10 read latency: address change shows next cycle
    @(negedge clk); bus_addr = 3'd1;
    @(negedge clk);
    chk(bus_rdata == 4'b0011, "R10 registered read", int'(bus_rdata), 3);

    // R1 disable gate on live request
    glb_en = 1'b0; #1;
    chk(irq_req == 1'b0, "R1 enable low masks", int'(irq_req), 0);
    glb_en = 1'b1; cpu_lvl = 3'd7; #1;
    chk(irq_req == 1'b0, "R5 cpu level 7 masks", int'(irq_req), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule